// File: doc/BRIEF.md
# Inverted Open-Drain Digital Point Bank

This block owns a bank of bidirectional digital points. Each point has a pad that can only be pulled low or released, so the far end is expected to have a pull-up. Host software sees the bank as a row of word-wide registers. A write sets the output latch bits of one word. A read returns the synchronised pin levels of one word with the polarity inverted, so a pin held low reads as 1.

A latch bit of 1 turns the pull-down on, which is the "on" state for a relay or lamp wired to the point. A latch bit of 0 releases the pad. A released pad can be driven by outside equipment, so every released point also works as an input. Reset clears all latch bits, which leaves the whole bank as inputs.

The number of points, the register word width and the synchroniser depth are parameters. When the point count is not a multiple of the word width, the last word is only partly filled.

Top module: `inv_od_port`

## Requirements
- R1: While reset is asserted, and right after it is released, every `pad_oe_low` bit is 0 and every word reads as 0, provided no outside device pulls a pin low.
- R2: A write with `wr_en`=1 to word W sets point W*WORD_W+b to `wr_data[b]`. A bit written as 1 makes `pad_oe_low` of that point go high from the rising edge that samples the write.
- R3: A latch bit written as 0 clears `pad_oe_low` of that point on the same edge, which releases the pad.
- R4: Bit b of `rd_data` for word `rd_addr` is the inverse of the synchronised level of point `rd_addr`*WORD_W+b. A low pin reads 1 and a high pin reads 0.
- R5: A change on `pad_in` shows on `rd_data` after exactly SYNC_STAGES rising edges. The default is 2. Until then `rd_data` keeps its previous value.
- R6: A point whose latch bit is 1 reads back as 1 once its own pull-down has passed through the synchroniser, whatever the outside equipment does.
- R7: A write to one word leaves the latch bits of every other word unchanged.
- R8: A write to an address at or above the number of words changes no latch bit. Reading such an address returns 0. Bit positions past the last point in the final word always read 0.
- R9: While `wr_en`=0, `pad_oe_low` does not change, whatever `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W (2) | Word index for the write |
| wr_data | input | WORD_W (8) | Latch bits for the addressed word |
| rd_addr | input | ADDR_W (2) | Word index for the combinational read |
| rd_data | output | WORD_W (8) | Inverted, synchronised pin levels of the addressed word |
| pad_oe_low | output | N_PTS (20) | Per-point pull-down enable, 1 = pin pulled low |
| pad_in | input | N_PTS (20) | Per-point sensed pin level |

## Verification
The read-path assertions assume that `pad_in` is the resolved level of an open-drain line with a pull-up: a point whose own `pad_oe_low` is high is expected to read low. The bench keeps to this by deriving `pad_in` from the design's pull-down outputs combined with a separate set of external pull-down requests. It never drives a pin high against an active pull-down. Write addresses range over the valid words and the first unused index, and all stimulus changes away from the clock edge, so each write is captured by a single edge.

// File: rtl/iop_pkg.sv
package iop_pkg;

   // number of register words needed to cover a point count
   function automatic int word_count(input int pts, input int w);
      return (pts + w - 1) / w;
   endfunction

   // address width for a word count, never below one bit
   function automatic int addr_bits(input int words);
      return (words > 1) ? $clog2(words) : 1;
   endfunction

   // number of live points in word idx
   function automatic int live_bits(input int pts, input int w, input int idx);
      int rest;
      rest = pts - idx * w;
      return (rest < w) ? rest : w;
   endfunction

endpackage

// File: rtl/iop_latch_bank.sv
module iop_latch_bank #(
   parameter int N_PTS   = 20,
   parameter int WORD_W  = 8,
   parameter int N_WORDS = 3,
   parameter int ADDR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [N_PTS-1:0]  latch_q
);

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      localparam int LO = w * WORD_W;
      localparam int NB = iop_pkg::live_bits(N_PTS, WORD_W, w);

      logic          hit;
      logic [NB-1:0] bits_q;

      assign hit = wr_en && (int'(wr_addr) == w);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q <= '0;
         end else if (hit) begin
            bits_q <= wr_data[NB-1:0];
         end
      end

      assign latch_q[LO +: NB] = bits_q;
   end

endmodule

// File: rtl/iop_sync.sv
module iop_sync #(
   parameter int WIDTH  = 20,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   // a released line idles high, so the chain resets to ones
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '1;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/iop_read_mux.sv
module iop_read_mux #(
   parameter int N_PTS   = 20,
   parameter int WORD_W  = 8,
   parameter int N_WORDS = 3,
   parameter int ADDR_W  = 2
) (
   input  logic [N_PTS-1:0]  level,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   localparam int FULL_W   = N_WORDS * WORD_W;
   localparam int PAD_BITS = FULL_W - N_PTS;

   logic [FULL_W-1:0] inv_full;

   if (PAD_BITS == 0) begin : g_exact
      assign inv_full = ~level;
   end else begin : g_padded
      assign inv_full = {{PAD_BITS{1'b0}}, ~level};
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < N_WORDS; w++) begin
         if (int'(rd_addr) == w) rd_data = inv_full[w*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/inv_od_port.sv
module inv_od_port #(
   parameter  int N_PTS       = 20,
   parameter  int WORD_W      = 8,
   parameter  int SYNC_STAGES = 2,
   localparam int N_WORDS     = iop_pkg::word_count(N_PTS, WORD_W),
   localparam int ADDR_W      = iop_pkg::addr_bits(N_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic [N_PTS-1:0]  pad_oe_low,
   input  logic [N_PTS-1:0]  pad_in
);

   if (N_PTS < 1 || WORD_W < 1) begin : g_bad_size
      $error("inv_od_port: N_PTS and WORD_W must be positive");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("inv_od_port: SYNC_STAGES must be 2..4");
   end

   logic [N_PTS-1:0] latch_q;
   logic [N_PTS-1:0] level_s;

   iop_latch_bank #(
      .N_PTS(N_PTS), .WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)
   ) i_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .latch_q(latch_q)
   );

   iop_sync #(
      .WIDTH(N_PTS), .STAGES(SYNC_STAGES)
   ) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(level_s)
   );

   iop_read_mux #(
      .N_PTS(N_PTS), .WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)
   ) i_rmux (
      .level(level_s), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // pull-down only: a set latch bit enables the driver
   assign pad_oe_low = latch_q;

endmodule

// File: rtl/iop_port_chk.sv
module iop_port_chk #(
   parameter int N_PTS       = 20,
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int N_WORDS     = 3,
   parameter int ADDR_W      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [WORD_W-1:0] rd_data,
   input logic [N_PTS-1:0]  pad_oe_low,
   input logic [N_PTS-1:0]  pad_in
);

   // edges seen since reset release, saturating at 2
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cyc <= '0;
      else if (cyc != 2'd2) cyc <= cyc + 2'd1;
   end

   always_comb begin
      if (!rst_n) AST_RESET_RELEASED: assert (pad_oe_low == '0); // R1
   end

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pad_oe_low)); // R9

   AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) >= N_WORDS) |=> $stable(pad_oe_low)); // R8

   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr) >= N_WORDS) |-> (rd_data == '0)); // R8

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      localparam int LO = w * WORD_W;
      localparam int NB = iop_pkg::live_bits(N_PTS, WORD_W, w);

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(wr_addr) == w) |=>
            (pad_oe_low[LO +: NB] == $past(wr_data[NB-1:0]))); // R2

      if (SYNC_STAGES == 2) begin : g_lat2
         AST_READ_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc == 2'd2 && int'(rd_addr) == w) |->
               (rd_data[NB-1:0] == ~$past(pad_in[LO +: NB], 2))); // R4
      end

      if (NB < WORD_W) begin : g_tail
         AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(rd_addr) == w) |-> (rd_data[WORD_W-1:NB] == '0)); // R8
      end
   end

endmodule

bind inv_od_port iop_port_chk #(
   .N_PTS(N_PTS), .WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES),
   .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .pad_oe_low(pad_oe_low), .pad_in(pad_in)
);

// File: tb/test_inv_od_port.sv
module test_inv_od_port;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 20;
   localparam int WW = 8;
   localparam int NW = 3;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [WW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [WW-1:0] rd_data;
   logic [NP-1:0] pad_oe_low;
   logic [NP-1:0] pad_in;
   logic [NP-1:0] ext_low = '0;

   // open-drain line with pull-up: low if anyone pulls it down
   assign pad_in = ~(pad_oe_low | ext_low);

   inv_od_port i_inv_od_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pad_oe_low(pad_oe_low), .pad_in(pad_in)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: latch integers and a history queue of pin levels
   int            m_latch [NP];
   logic [NP-1:0] pin_hist [$];

   function automatic logic [NP-1:0] model_pins();
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = !((m_latch[i] != 0) || ext_low[i]);
      return v;
   endfunction

   function automatic logic [WW-1:0] model_read(input int a);
      logic [WW-1:0] r = '0;
      if (a < NW) begin
         for (int b = 0; b < WW; b++) begin
            if (a*WW + b < NP) r[b] = !pin_hist[0][a*WW + b];
         end
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_latch[i]) m_latch[i] = 0;
         pin_hist = {};
         pin_hist.push_back('1);
         pin_hist.push_back('1);
      end else begin
         pin_hist.push_back(model_pins());
         void'(pin_hist.pop_front());
         if (wr_en && int'(wr_addr) < NW) begin
            for (int b = 0; b < WW; b++) begin
               if (int'(wr_addr)*WW + b < NP) m_latch[int'(wr_addr)*WW + b] = int'(wr_data[b]);
            end
         end
      end
      #1;
      if (!done && pin_hist.size() == 2) begin
         logic [NP-1:0] exp_oe;
         for (int i = 0; i < NP; i++) exp_oe[i] = (m_latch[i] != 0);
         check("R2/R3 pad_oe_low per-cycle", 32'(pad_oe_low), 32'(exp_oe));
         check("R4 rd_data per-cycle", 32'(rd_data), 32'(model_read(int'(rd_addr))));
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic peek(input int a, input string tag, input logic [WW-1:0] exp);
      rd_addr = AW'(a);
      #1;
      check(tag, 32'(rd_data), 32'(exp));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) tick();
      check("R1 oe in reset", 32'(pad_oe_low), 32'h0);
      for (int a = 0; a < NW; a++) peek(a, "R1 read in reset", 8'h00);
      rst_n = 1'b1;
      tick();
      check("R1 oe after release", 32'(pad_oe_low), 32'h0);
      peek(1, "R1 read after release", 8'h00);

      // R2, R7: write word 0
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hA5;
      tick();
      wr_en = 1'b0;
      check("R2 oe word0", 32'(pad_oe_low[7:0]), 32'hA5);
      check("R7 other words untouched", 32'(pad_oe_low[19:8]), 32'h0);
      // R6: own pull-down reads back once through the synchroniser
      peek(0, "R5 not yet visible", 8'h00);
      tick();
      peek(0, "R5 one edge later", 8'h00);
      tick();
      peek(0, "R6 loopback", 8'hA5);

      // R3: release upper nibble
      wr_en = 1'b1; wr_data = 8'h0F;
      tick();
      wr_en = 1'b0;
      check("R3 released bits", 32'(pad_oe_low[7:0]), 32'h0F);

      // R4, R5: external pull on point 9 (word 1 bit 1)
      rd_addr = 2'd1;
      ext_low[9] = 1'b1;
      tick();
      peek(1, "R5 after one edge", 8'h00);
      tick();
      peek(1, "R4 low pin reads one", 8'h02);
      ext_low[9] = 1'b0;
      tick(); tick();
      peek(1, "R4 high pin reads zero", 8'h00);

      // R6: point 11 driven by latch, outside pull irrelevant
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h08;
      tick();
      wr_en = 1'b0;
      check("R7 word0 kept", 32'(pad_oe_low[7:0]), 32'h0F);
      ext_low[11] = 1'b1;
      tick(); tick();
      peek(1, "R6 driven point", 8'h08);
      ext_low[11] = 1'b0;
      tick(); tick();
      peek(1, "R6 driven point no outside pull", 8'h08);

      // R8: out-of-range write and read, tail bits of last word
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hFF;
      tick();
      wr_en = 1'b0;
      check("R8 oor write ignored", 32'(pad_oe_low), 32'h0080F);
      peek(3, "R8 oor read zero", 8'h00);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'hFF;
      tick();
      wr_en = 1'b0;
      check("R8 last word live bits", 32'(pad_oe_low[19:16]), 32'hF);
      tick(); tick();
      peek(2, "R8 tail bits read zero", 8'h0F);

      // R9: no strobe, busy address and data
      for (int k = 0; k < 4; k++) begin
         wr_addr = AW'(k); wr_data = 8'h5A ^ 8'(k);
         tick();
         check("R9 no strobe no change", 32'(pad_oe_low), 32'hF080F);
      end

      // mixed traffic, judged by the per-cycle model
      for (int k = 0; k < 400; k++) begin
         wr_en   = ($urandom_range(0, 2) == 0);
         wr_addr = AW'($urandom_range(0, 3));
         wr_data = WW'($urandom);
         rd_addr = AW'($urandom_range(0, 3));
         ext_low = NP'($urandom) & NP'($urandom);
         tick();
      end
      wr_en = 1'b0;
      tick();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule